// File: doc/BRIEF.md
# QoS-Weighted Shared Memory Port Arbiter

This block sits in front of one shared SRAM port and decides, every clock cycle, which of seven host ports may use it. Each host port has its own programmable 2-bit service level. The grant goes first to the highest service level among the eligible requesters. Among requesters at that level, the lowest port number wins. The grant is combinational, so a winning request is granted in the cycle it is presented. The only exception is a port at one of the two lowest service levels. Such a port must first have held its request for one full cycle.

A host raises its request and keeps it up until it sees its grant. If it also raises its hold line while granted, the arbiter keeps the port for the next cycle, as long as that port is still requesting. This lets a multi-beat access finish without interruption. Software sets the service levels through a small register interface with byte enables. Port 0 holds the processor-facing level and accepts only full-word writes.

Top module: `qos_mem_arbiter`

## Requirements
- R1: The service level is a 2-bit code: 0 background, 1 bandwidth-sensitive, 2 latency-sensitive, 3 latency-critical. Among eligible requesters, the one with the numerically highest level is granted.
- R2: When several eligible requesters share the highest level, the lowest port number is granted.
- R3: A port at level 0 or 1 is not granted in the first cycle of a continuous request. It becomes eligible from the second cycle on. The count restarts when the request drops or after the port is granted.
- R4: A port at level 2 or 3 can be granted in the same cycle its request first appears.
- R5: After reset, port 0 reads level 3 and ports 1 to 6 read level 2.
- R6: The level register of port 0 (address 0, level in bits [1:0], all other read bits zero) changes only on a write with all four byte enables set. A write with any other byte-enable pattern leaves it unchanged.
- R7: Ports 1 to 6 (addresses 1 to 6) take bits [1:0] of the write data when byte enable bit 0 is set, and ignore the write otherwise. Address 7 ignores writes and reads as zero.
- R8: A level write is used for arbitration and readback from the cycle after the write.
- R9: At most one grant bit is high per cycle. The grant-valid output is high exactly when a grant bit is high, and the grant index names that bit. With no eligible requester, no grant is given.
- R10: If the granted port has its hold line high, the next cycle grants that port again whenever it still requests, regardless of the other requesters.
- R11: A grant is only ever given to a port whose request is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 7 | Per-port access request |
| hold_i | input | 7 | Per-port request to keep the grant next cycle |
| gnt_o | output | 7 | One-hot grant |
| gnt_valid_o | output | 1 | A grant is given this cycle |
| gnt_idx_o | output | 3 | Number of the granted port |
| cfg_we_i | input | 1 | Level register write strobe |
| cfg_addr_i | input | 3 | Level register address (port number) |
| cfg_wdata_i | input | 32 | Write data |
| cfg_be_i | input | 4 | Write byte enables |
| cfg_rdata_o | output | 32 | Read data for the addressed register |

## Verification
The bench targets three corner cases.

- A low-level port that requests alone must sit out exactly one cycle. If the wait counter never restarts after a dropped request, the port is granted one cycle early. If the wait is applied to the upper levels as well, every latency-sensitive grant arrives a cycle late.
- Narrow writes to port 0, and writes to ports 1 to 6 without byte 0 enabled, must leave the stored level untouched. A decoder that ignores the byte enables lets such writes change the level.
- When two ports share a level, the lower number must win. When a port locks the grant with hold, it must keep it over a higher-level competitor. A picker that scans in the wrong direction, or a lock that does not check the owner's request, breaks these cases.

// File: rtl/qos_arb_pkg.sv
package qos_arb_pkg;

    localparam int QOS_W = 2;

    typedef enum logic [QOS_W-1:0] {
        QOS_BACKGROUND = 2'd0,
        QOS_BANDWIDTH  = 2'd1,
        QOS_LATENCY    = 2'd2,
        QOS_CRITICAL   = 2'd3
    } qos_level_e;

    // Lowest level that may be granted without the one-cycle wait.
    localparam logic [QOS_W-1:0] QOS_NO_WAIT_MIN = QOS_LATENCY;

    function automatic logic [QOS_W-1:0] qos_reset_level(input int port, input int strict_port);
        return (port == strict_port) ? QOS_CRITICAL : QOS_LATENCY;
    endfunction

endpackage

// File: rtl/qos_cfg_regs.sv
module qos_cfg_regs
    import qos_arb_pkg::*;
#(
    parameter int NUM_PORTS   = 7,
    parameter int CFG_DW      = 32,
    parameter int CFG_AW      = 3,
    parameter int STRICT_PORT = 0,
    localparam int BE_W       = CFG_DW / 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 we_i,
    input  logic [CFG_AW-1:0]                    addr_i,
    input  logic [CFG_DW-1:0]                    wdata_i,
    input  logic [BE_W-1:0]                      be_i,
    output logic [CFG_DW-1:0]                    rdata_o,
    output logic [NUM_PORTS-1:0][QOS_W-1:0]      qos_o
);

    typedef struct packed {
        logic [NUM_PORTS-1:0][QOS_W-1:0] lvl;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    logic [NUM_PORTS-1:0] wr_ok;

    // One write-accept term per port; the strict port needs every byte lane.
    for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_wr
        if (gp == STRICT_PORT) begin : g_strict
            assign wr_ok[gp] = we_i && (addr_i == CFG_AW'(gp)) && (&be_i);
        end else begin : g_loose
            assign wr_ok[gp] = we_i && (addr_i == CFG_AW'(gp)) && be_i[0];
        end
    end

    always_comb begin
        st_d = st_q;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (wr_ok[p]) begin
                st_d.lvl[p] = wdata_i[QOS_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                st_q.lvl[p] <= qos_reset_level(p, STRICT_PORT);
            end
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (addr_i == CFG_AW'(p)) begin
                rdata_o[QOS_W-1:0] = st_q.lvl[p];
            end
        end
    end

    assign qos_o = st_q.lvl;

endmodule

// File: rtl/qos_eligibility.sv
module qos_eligibility
    import qos_arb_pkg::*;
#(
    parameter int NUM_PORTS = 7
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_PORTS-1:0]            req_i,
    input  logic [NUM_PORTS-1:0]            gnt_i,
    input  logic [NUM_PORTS-1:0][QOS_W-1:0] qos_i,
    output logic [NUM_PORTS-1:0]            elig_o
);

    typedef struct packed {
        logic [NUM_PORTS-1:0] waited;
    } elig_state_t;

    elig_state_t st_d, st_q;

    always_comb begin
        // A port has waited once its request survived a cycle ungranted.
        st_d.waited = req_i & ~gnt_i;
        for (int p = 0; p < NUM_PORTS; p++) begin
            elig_o[p] = req_i[p] && ((qos_i[p] >= QOS_NO_WAIT_MIN) || st_q.waited[p]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/qos_pick.sv
module qos_pick
    import qos_arb_pkg::*;
#(
    parameter int NUM_PORTS = 7,
    localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic [NUM_PORTS-1:0]            elig_i,
    input  logic [NUM_PORTS-1:0][QOS_W-1:0] qos_i,
    output logic                            valid_o,
    output logic [IDX_W-1:0]                idx_o
);

    logic [QOS_W-1:0] best_lvl;

    // Scan from the highest port number down; >= lets lower numbers take ties.
    always_comb begin
        valid_o  = 1'b0;
        idx_o    = '0;
        best_lvl = '0;
        for (int p = NUM_PORTS - 1; p >= 0; p--) begin
            if (elig_i[p] && (!valid_o || (qos_i[p] >= best_lvl))) begin
                valid_o  = 1'b1;
                idx_o    = IDX_W'(p);
                best_lvl = qos_i[p];
            end
        end
    end

endmodule

// File: rtl/qos_mem_arbiter.sv
module qos_mem_arbiter
    import qos_arb_pkg::*;
#(
    parameter int NUM_PORTS   = 7,
    parameter int CFG_DW      = 32,
    parameter int CFG_AW      = 3,
    parameter int STRICT_PORT = 0,
    localparam int IDX_W      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int BE_W       = CFG_DW / 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] req_i,
    input  logic [NUM_PORTS-1:0] hold_i,
    output logic [NUM_PORTS-1:0] gnt_o,
    output logic                 gnt_valid_o,
    output logic [IDX_W-1:0]     gnt_idx_o,
    input  logic                 cfg_we_i,
    input  logic [CFG_AW-1:0]    cfg_addr_i,
    input  logic [CFG_DW-1:0]    cfg_wdata_i,
    input  logic [BE_W-1:0]      cfg_be_i,
    output logic [CFG_DW-1:0]    cfg_rdata_o
);

    typedef struct packed {
        logic             active;
        logic [IDX_W-1:0] owner;
    } lock_t;

    lock_t lock_d, lock_q;

    logic [NUM_PORTS-1:0][QOS_W-1:0] qos_lvl;
    logic [NUM_PORTS-1:0]            elig;
    logic                            pick_valid;
    logic [IDX_W-1:0]                pick_idx;
    logic                            lock_hit;

    qos_cfg_regs #(
        .NUM_PORTS   (NUM_PORTS),
        .CFG_DW      (CFG_DW),
        .CFG_AW      (CFG_AW),
        .STRICT_PORT (STRICT_PORT)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .addr_i  (cfg_addr_i),
        .wdata_i (cfg_wdata_i),
        .be_i    (cfg_be_i),
        .rdata_o (cfg_rdata_o),
        .qos_o   (qos_lvl)
    );

    qos_eligibility #(
        .NUM_PORTS (NUM_PORTS)
    ) u_elig (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req_i),
        .gnt_i  (gnt_o),
        .qos_i  (qos_lvl),
        .elig_o (elig)
    );

    qos_pick #(
        .NUM_PORTS (NUM_PORTS)
    ) u_pick (
        .elig_i  (elig),
        .qos_i   (qos_lvl),
        .valid_o (pick_valid),
        .idx_o   (pick_idx)
    );

    always_comb begin
        lock_hit = lock_q.active && req_i[lock_q.owner];
        gnt_o    = '0;
        if (lock_hit) begin
            gnt_valid_o = 1'b1;
            gnt_idx_o   = lock_q.owner;
        end else begin
            gnt_valid_o = pick_valid;
            gnt_idx_o   = pick_idx;
        end
        if (gnt_valid_o) begin
            gnt_o[gnt_idx_o] = 1'b1;
        end
        lock_d.active = gnt_valid_o && hold_i[gnt_idx_o];
        lock_d.owner  = gnt_idx_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= '0;
        end else begin
            lock_q <= lock_d;
        end
    end

endmodule

// File: rtl/qos_arb_chk.sv
module qos_arb_chk
    import qos_arb_pkg::*;
#(
    parameter int NUM_PORTS   = 7,
    parameter int CFG_DW      = 32,
    parameter int CFG_AW      = 3,
    parameter int STRICT_PORT = 0,
    localparam int IDX_W      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int BE_W       = CFG_DW / 8
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [NUM_PORTS-1:0]            req_i,
    input logic [NUM_PORTS-1:0]            hold_i,
    input logic [NUM_PORTS-1:0]            gnt_o,
    input logic                            gnt_valid_o,
    input logic [IDX_W-1:0]                gnt_idx_o,
    input logic                            cfg_we_i,
    input logic [CFG_AW-1:0]               cfg_addr_i,
    input logic [CFG_DW-1:0]               cfg_wdata_i,
    input logic [BE_W-1:0]                 cfg_be_i,
    input logic [NUM_PORTS-1:0][QOS_W-1:0] qos_lvl
);

    // R9
    onehot_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    // R9
    valid_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid_o == (gnt_o != '0));

    // R11
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o & ~req_i) == '0);

    // R6
    strict_full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && cfg_addr_i == CFG_AW'(STRICT_PORT) && (&cfg_be_i))
        |=> qos_lvl[STRICT_PORT] == $past(cfg_wdata_i[QOS_W-1:0]));

    // R6
    strict_narrow_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && cfg_addr_i == CFG_AW'(STRICT_PORT) && !(&cfg_be_i))
        |=> $stable(qos_lvl[STRICT_PORT]));

    // R10
    hold_keeps_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid_o && hold_i[gnt_idx_o])
        |=> (!req_i[$past(gnt_idx_o)] || gnt_o[$past(gnt_idx_o)]));

    for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_port
        // R3
        low_qos_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(req_i[gp]) && qos_lvl[gp] < QOS_NO_WAIT_MIN) |-> !gnt_o[gp]);
    end

endmodule

bind qos_mem_arbiter qos_arb_chk #(
    .NUM_PORTS   (NUM_PORTS),
    .CFG_DW      (CFG_DW),
    .CFG_AW      (CFG_AW),
    .STRICT_PORT (STRICT_PORT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .hold_i      (hold_i),
    .gnt_o       (gnt_o),
    .gnt_valid_o (gnt_valid_o),
    .gnt_idx_o   (gnt_idx_o),
    .cfg_we_i    (cfg_we_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_be_i    (cfg_be_i),
    .qos_lvl     (qos_lvl)
);

// File: tb/qos_mem_arbiter_bench.sv
`timescale 1ns/1ps
module qos_mem_arbiter_bench;

    localparam int N = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic [N-1:0] hold = '0;
    logic [N-1:0] gnt;
    logic        gnt_valid;
    logic [2:0]  gnt_idx;
    logic        we = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  be = '0;
    logic [31:0] rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Bench-side model state
    int m_qos[N];
    bit m_wait[N];
    bit m_lock;
    int m_owner;
    logic [N-1:0] last_gnt;

    always #2.5 clk = ~clk;

    qos_mem_arbiter u_qos_mem_arbiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .hold_i      (hold),
        .gnt_o       (gnt),
        .gnt_valid_o (gnt_valid),
        .gnt_idx_o   (gnt_idx),
        .cfg_we_i    (we),
        .cfg_addr_i  (addr),
        .cfg_wdata_i (wdata),
        .cfg_be_i    (be),
        .cfg_rdata_o (rdata)
    );

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic int exp_pick();
        int best = -1;
        int bl = 0;
        if (m_lock && req[m_owner]) return m_owner;
        for (int p = N - 1; p >= 0; p--) begin
            if (req[p] && (m_qos[p] >= 2 || m_wait[p]) && (best < 0 || m_qos[p] >= bl)) begin
                best = p;
                bl   = m_qos[p];
            end
        end
        return best;
    endfunction

    function automatic int exp_read();
        return (addr < 3'd7) ? m_qos[addr] : 0;
    endfunction

    // Inputs are set just after a falling edge; outputs are sampled 1 ns later.
    task automatic run_cycle(input string tag);
        int e;
        logic [N-1:0] ev;
        #1;
        e  = exp_pick();
        ev = '0;
        if (e >= 0) ev[e] = 1'b1;
        check(gnt == ev, {tag, " grant vector"}, gnt, ev);
        check(gnt_valid == (e >= 0), {tag, " R9 grant valid"}, gnt_valid, e >= 0);
        if (e >= 0) check(gnt_idx == e[2:0], {tag, " R9 grant index"}, gnt_idx, e);
        check(rdata == 32'(exp_read()), {tag, " level readback"}, rdata, exp_read());
        @(posedge clk);
        for (int p = 0; p < N; p++) m_wait[p] = req[p] && !ev[p];
        m_lock  = (e >= 0) && hold[e];
        m_owner = (e >= 0) ? e : 0;
        if (we && addr < 3'd7) begin
            if (addr == 3'd0 ? (be == 4'hF) : be[0]) m_qos[addr] = int'(wdata[1:0]);
        end
        last_gnt = ev;
        @(negedge clk);
        we   = 1'b0;
        be   = '0;
    endtask

    task automatic cfg_write(input int a, input int d, input logic [3:0] b, input string tag);
        we = 1'b1; addr = 3'(a); wdata = 32'(d); be = b;
        run_cycle(tag);
    endtask

    initial begin
        #(5.0 * 150000);
        check(1'b0, "watchdog expired", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int p = 0; p < N; p++) begin
            m_qos[p]  = (p == 0) ? 3 : 2;
            m_wait[p] = 0;
        end
        m_lock = 0; m_owner = 0; last_gnt = '0;
        repeat (3) @(negedge clk);
        #1;
        check(gnt == '0 && !gnt_valid, "R9 no grant in reset", gnt, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R5 reset levels, R7 address 7 reads zero
        for (int a = 0; a < 8; a++) begin
            addr = 3'(a);
            #1;
            check(rdata == ((a == 0) ? 32'd3 : (a == 7) ? 32'd0 : 32'd2), "R5 reset level", rdata, a);
            run_cycle("R5 idle");
        end

        // R1 higher level wins over lower number of lower level and vice versa
        req = 7'b1000001;
        run_cycle("R1 critical vs latency");
        req &= ~last_gnt;
        run_cycle("R1 remaining port");
        req &= ~last_gnt;

        // R2 ties go to the lower number
        req = 7'b0101000;
        run_cycle("R2 tie");
        req &= ~last_gnt;
        run_cycle("R2 tie rest");
        req = '0;

        // R6 narrow write to port 0 ignored; full write taken next cycle (R8)
        cfg_write(0, 0, 4'h3, "R6 narrow write");
        addr = 3'd0;
        run_cycle("R6 level unchanged");
        cfg_write(0, 1, 4'hF, "R6 full write");
        addr = 3'd0;
        run_cycle("R8 new level visible");

        // R3 level-1 port waits one cycle
        req = 7'b0000001;
        run_cycle("R3 first cycle no grant");
        run_cycle("R3 second cycle granted");
        req = '0;
        run_cycle("R3 idle");

        // R3 restart after a dropped request (port 1 to level 0)
        cfg_write(1, 0, 4'h1, "R7 write port 1");
        req = 7'b0000010;
        run_cycle("R3 restart first");
        req = '0;
        run_cycle("R3 drop");
        req = 7'b0000010;
        run_cycle("R3 restart again no grant");
        run_cycle("R3 restart granted");
        req = '0;

        // R4 level-2 port granted at once; R11 no grant to idle ports
        req = 7'b0000100;
        run_cycle("R4 immediate grant");
        req = '0;
        run_cycle("R11 idle no grant");

        // R10 hold keeps the grant against a higher-level requester
        cfg_write(1, 3, 4'h1, "R7 port 1 critical");
        req = 7'b0010000; hold = 7'b0010000;
        run_cycle("R10 lock taken");
        req = 7'b0010010;
        run_cycle("R10 locked over critical");
        hold = '0;
        run_cycle("R10 last locked beat");
        req = 7'b0000010;
        run_cycle("R10 released");
        req = '0;

        // R7 ignored writes
        cfg_write(7, 1, 4'hF, "R7 address 7 write");
        cfg_write(5, 0, 4'h2, "R7 no byte 0");
        addr = 3'd5;
        run_cycle("R7 port 5 unchanged");
        addr = 3'd7;
        run_cycle("R7 address 7 zero");

        // Constrained random traffic
        void'($urandom(32'h5EED_0A7B));
        for (int c = 0; c < 4000; c++) begin
            for (int p = 0; p < N; p++) begin
                if (last_gnt[p] && ($urandom % 10) < 8) req[p] = 1'b0;
                else if (!req[p] && ($urandom % 10) < 3) req[p] = 1'b1;
                else if (req[p] && ($urandom % 100) < 3) req[p] = 1'b0;
                hold[p] = (($urandom % 10) < 2);
            end
            addr = 3'($urandom % 8);
            if (($urandom % 20) == 0) begin
                we    = 1'b1;
                wdata = $urandom;
                be    = 4'($urandom);
                if (($urandom % 2) == 0) be = 4'hF;
            end
            run_cycle("R1 R2 R3 R4 R9 R10 R11 random");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule